// File: doc/BRIEF.md
# Dual-Strobe Up/Down Counter

This block is a binary up/down counter, four bits wide by default, that moves on strobes rather than on a direction bit. It has one strobe for counting up and one for counting down. Both strobes idle HIGH and are asynchronous to the system clock. Each strobe passes through a multi-flop synchroniser, and its rising edge is found by comparing the synchronised level with the level one cycle earlier.

An active-high clear forces the count to zero. An active-low load copies a data word into the count. Both act on the system clock edge, and each overrides the strobes.

Two active-low terminal outputs let stages chain without glue logic. The carry copies the LOW phase of the up strobe while the count is at its maximum. The borrow does the same with the down strobe while the count is zero. Wiring one stage's carry to the next stage's up strobe, and its borrow to the next stage's down strobe, builds a wider counter.

Top module: `dual_strobe_counter`

## Requirements
- R1: A rising edge on the up strobe, while the synchronised down strobe is HIGH, adds one to the count. The count wraps from the maximum (15 at the default width) to 0.
- R2: A rising edge on the down strobe, while the synchronised up strobe is HIGH, subtracts one from the count. The count wraps from 0 to the maximum.
- R3: When `clr` is HIGH at a clock edge, the count becomes 0 at that edge. This takes priority over the load and over both strobes.
- R4: When `clr` is LOW and `load_n` is LOW at a clock edge, the count takes the value of `din` at that edge, whatever the strobes are doing.
- R5: Synchronous reset `rst` sets the count to 0 and drives `carry_n` and `borrow_n` HIGH. Both terminal outputs are HIGH whenever their terminal condition does not hold.
- R6: While the count is at its maximum and the synchronised up strobe is LOW, `carry_n` is LOW. `carry_n` goes HIGH on the same clock edge on which the count wraps to 0 after the up strobe rises.
- R7: While the count is 0 and the synchronised down strobe is LOW, `borrow_n` is LOW. `borrow_n` goes HIGH on the same clock edge on which the count wraps to the maximum after the down strobe rises.
- R8: If a strobe is held LOW during a clear or a load and stays LOW afterwards, its next rising edge is counted.
- R9: If rising edges of both strobes are detected in the same system cycle, the count does not change.
- R10: A rising edge of one strobe is ignored if the synchronised level of the other strobe is LOW at that time.
- R11: A strobe change that is set up before clock edge n changes the count at edge n+2. With the default two-flop synchroniser this is the third rising clock edge that sees the new level.
- R12: Two stages cascade directly: the low stage's `carry_n` drives the high stage's up strobe and its `borrow_n` drives the high stage's down strobe. The pair then counts as one eight-bit counter across both carry and borrow.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous reset, active high |
| clr | input | 1 | Master clear, active high, synchronous |
| load_n | input | 1 | Parallel load, active low, synchronous |
| din | input | WIDTH | Parallel load data |
| up_strb | input | 1 | Count-up strobe, idles HIGH, asynchronous |
| dn_strb | input | 1 | Count-down strobe, idles HIGH, asynchronous |
| count | output | WIDTH | Current count |
| carry_n | output | 1 | Terminal count up, active low |
| borrow_n | output | 1 | Terminal count down, active low |

## Verification
On every cycle the assertions check the following:
- the clear priority;
- the load value;
- that the count never moves more than one step without a clear or a load;
- that coincident rising edges leave the count unchanged;
- that a LOW carry or borrow only ever follows a terminal count.

Some behaviour shows only in the directed scenarios:
- the exact synchroniser latency;
- wrap-around in both directions;
- that an edge is counted after a strobe is held LOW through a load or a clear;
- that an edge is ignored while the opposite strobe is LOW;
- the carry ripple between two chained stages.

// File: rtl/dsc_pkg.sv
package dsc_pkg;

    typedef enum logic [2:0] {
        OP_HOLD  = 3'd0,
        OP_INC   = 3'd1,
        OP_DEC   = 3'd2,
        OP_LOAD  = 3'd3,
        OP_CLEAR = 3'd4
    } op_e;

    typedef struct packed {
        logic level;
        logic rise;
    } strobe_t;

    // Clear beats load, load beats strobes. A strobe edge counts only while
    // the opposite strobe rests HIGH and has no edge of its own.
    function automatic op_e pick_op(input logic clr,
                                    input logic load_n,
                                    input strobe_t up,
                                    input strobe_t dn);
        op_e op;
        if (clr)
            op = OP_CLEAR;
        else if (!load_n)
            op = OP_LOAD;
        else if (up.rise && !dn.rise && dn.level)
            op = OP_INC;
        else if (dn.rise && !up.rise && up.level)
            op = OP_DEC;
        else
            op = OP_HOLD;
        return op;
    endfunction

endpackage

// File: rtl/dsc_strobe_sync.sv
module dsc_strobe_sync
    import dsc_pkg::*;
#(
    parameter int STAGES = 2
) (
    input  logic    clk,
    input  logic    rst,
    input  logic    strb_in,
    output strobe_t strb_out
);

    logic [STAGES-1:0] chain;
    logic              prev;

    for (genvar i = 0; i < STAGES; i++) begin : g_stage
        if (i == 0) begin : g_first
            always_ff @(posedge clk) begin
                if (rst) chain[i] <= 1'b1;
                else     chain[i] <= strb_in;
            end
        end else begin : g_next
            always_ff @(posedge clk) begin
                if (rst) chain[i] <= 1'b1;
                else     chain[i] <= chain[i-1];
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) prev <= 1'b1;
        else     prev <= chain[STAGES-1];
    end

    always_comb begin
        strb_out.level = chain[STAGES-1];
        strb_out.rise  = chain[STAGES-1] & ~prev;
    end

endmodule

// File: rtl/dsc_count_core.sv
module dsc_count_core
    import dsc_pkg::*;
#(
    parameter int WIDTH = 4
) (
    input  logic             clk,
    input  logic             rst,
    input  op_e              op,
    input  logic [WIDTH-1:0] din,
    output logic [WIDTH-1:0] count
);

    logic [WIDTH-1:0] next_count;

    always_comb begin
        unique case (op)
            OP_CLEAR: next_count = '0;
            OP_LOAD:  next_count = din;
            OP_INC:   next_count = count + WIDTH'(1);
            OP_DEC:   next_count = count - WIDTH'(1);
            default:  next_count = count;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) count <= '0;
        else     count <= next_count;
    end

endmodule

// File: rtl/dsc_term_gen.sv
module dsc_term_gen #(
    parameter int WIDTH = 4
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [WIDTH-1:0] count,
    input  logic             up_level,
    input  logic             dn_level,
    output logic             carry_n,
    output logic             borrow_n
);

    localparam logic [WIDTH-1:0] TOP = '1;

    logic at_top;
    logic at_zero;

    assign at_top  = (count == TOP);
    assign at_zero = (count == '0);

    always_ff @(posedge clk) begin
        if (rst) begin
            carry_n  <= 1'b1;
            borrow_n <= 1'b1;
        end else begin
            carry_n  <= ~(at_top  & ~up_level);
            borrow_n <= ~(at_zero & ~dn_level);
        end
    end

endmodule

// File: rtl/dual_strobe_counter.sv
module dual_strobe_counter
    import dsc_pkg::*;
#(
    parameter int WIDTH       = 4,
    parameter int SYNC_STAGES = 2
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             clr,
    input  logic             load_n,
    input  logic [WIDTH-1:0] din,
    input  logic             up_strb,
    input  logic             dn_strb,
    output logic [WIDTH-1:0] count,
    output logic             carry_n,
    output logic             borrow_n
);

    strobe_t up_s;
    strobe_t dn_s;
    op_e     op;
    logic    up_rise;
    logic    dn_rise;

    dsc_strobe_sync #(.STAGES(SYNC_STAGES)) u_up_sync (
        .clk      (clk),
        .rst      (rst),
        .strb_in  (up_strb),
        .strb_out (up_s)
    );

    dsc_strobe_sync #(.STAGES(SYNC_STAGES)) u_dn_sync (
        .clk      (clk),
        .rst      (rst),
        .strb_in  (dn_strb),
        .strb_out (dn_s)
    );

    assign up_rise = up_s.rise;
    assign dn_rise = dn_s.rise;
    assign op      = pick_op(clr, load_n, up_s, dn_s);

    dsc_count_core #(.WIDTH(WIDTH)) u_core (
        .clk   (clk),
        .rst   (rst),
        .op    (op),
        .din   (din),
        .count (count)
    );

    dsc_term_gen #(.WIDTH(WIDTH)) u_term (
        .clk      (clk),
        .rst      (rst),
        .count    (count),
        .up_level (up_s.level),
        .dn_level (dn_s.level),
        .carry_n  (carry_n),
        .borrow_n (borrow_n)
    );

endmodule

// File: rtl/dual_strobe_counter_chk.sv
module dual_strobe_counter_chk #(
    parameter int WIDTH = 4
) (
    input logic             clk,
    input logic             rst,
    input logic             clr,
    input logic             load_n,
    input logic [WIDTH-1:0] din,
    input logic [WIDTH-1:0] count,
    input logic             carry_n,
    input logic             borrow_n,
    input logic             up_rise,
    input logic             dn_rise
);

    localparam logic [WIDTH-1:0] TOP = '1;

    // R3: clear wins over everything
    a_r3_clear_zero: assert property (@(posedge clk) disable iff (rst)
        clr |=> (count == '0));

    // R4: load copies the data word
    a_r4_load_copy: assert property (@(posedge clk) disable iff (rst)
        (!clr && !load_n) |=> (count == $past(din)));

    // R1 / R2: without clear or load the count moves at most one step
    a_r1_single_step: assert property (@(posedge clk) disable iff (rst)
        (clr == 1'b0 && load_n == 1'b1) |=>
            (count == $past(count) ||
             count == WIDTH'($past(count) + WIDTH'(1)) ||
             count == WIDTH'($past(count) - WIDTH'(1))));

    // R9: coincident edges hold the count
    a_r9_both_hold: assert property (@(posedge clk) disable iff (rst)
        (up_rise && dn_rise && !clr && load_n) |=> $stable(count));

    // R6: carry LOW only after a maximum count
    a_r6_carry_top: assert property (@(posedge clk) disable iff (rst)
        !carry_n |-> ($past(count) == TOP));

    // R7: borrow LOW only after a zero count
    a_r7_borrow_zero: assert property (@(posedge clk) disable iff (rst)
        !borrow_n |-> ($past(count) == '0));

endmodule

bind dual_strobe_counter dual_strobe_counter_chk #(.WIDTH(WIDTH)) u_chk (
    .clk      (clk),
    .rst      (rst),
    .clr      (clr),
    .load_n   (load_n),
    .din      (din),
    .count    (count),
    .carry_n  (carry_n),
    .borrow_n (borrow_n),
    .up_rise  (up_rise),
    .dn_rise  (dn_rise)
);

// File: tb/tb_dual_strobe_counter.sv
module tb_dual_strobe_counter;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       clr = 1'b0;
    logic       load_n = 1'b1;
    logic [3:0] din = 4'd0;
    logic       up = 1'b1;
    logic       dn = 1'b1;
    logic [3:0] count;
    logic       carry_n;
    logic       borrow_n;

    // cascade pair
    logic       c_up = 1'b1;
    logic       c_dn = 1'b1;
    logic [3:0] lo_cnt, hi_cnt;
    logic       lo_carry, lo_borrow, hi_carry, hi_borrow;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #4 clk = ~clk;

    dual_strobe_counter dut (
        .clk(clk), .rst(rst), .clr(clr), .load_n(load_n), .din(din),
        .up_strb(up), .dn_strb(dn),
        .count(count), .carry_n(carry_n), .borrow_n(borrow_n)
    );

    dual_strobe_counter lo_stage (
        .clk(clk), .rst(rst), .clr(1'b0), .load_n(1'b1), .din(4'd0),
        .up_strb(c_up), .dn_strb(c_dn),
        .count(lo_cnt), .carry_n(lo_carry), .borrow_n(lo_borrow)
    );

    dual_strobe_counter hi_stage (
        .clk(clk), .rst(rst), .clr(1'b0), .load_n(1'b1), .din(4'd0),
        .up_strb(lo_carry), .dn_strb(lo_borrow),
        .count(hi_cnt), .carry_n(hi_carry), .borrow_n(hi_borrow)
    );

    task automatic tick(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic check(input string req, input int act, input int exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic pulse_up();
        up = 1'b0; tick(4);
        up = 1'b1; tick(4);
    endtask

    task automatic pulse_dn();
        dn = 1'b0; tick(4);
        dn = 1'b1; tick(4);
    endtask

    task automatic t_reset();
        rst = 1'b1; tick(3);
        check("R5 reset count", count, 0);
        check("R5 reset carry_n", carry_n, 1);
        check("R5 reset borrow_n", borrow_n, 1);
        rst = 1'b0; tick(2);
        check("R5 idle carry_n", carry_n, 1);
        check("R5 idle borrow_n", borrow_n, 1);
    endtask

    task automatic t_latency();
        up = 1'b0; tick(5);
        up = 1'b1; tick(2);
        check("R11 not yet counted", count, 0);
        tick(1);
        check("R11 R1 counted on third edge", count, 1);
        tick(3);
    endtask

    task automatic t_up_wrap();
        for (int i = 0; i < 14; i++) pulse_up();
        check("R1 count up to 15", count, 15);
        check("R6 carry high while up high", carry_n, 1);
        up = 1'b0; tick(4);
        check("R6 carry low at 15", carry_n, 0);
        check("R6 carry_n vs borrow_n", borrow_n, 1);
        up = 1'b1; tick(4);
        check("R1 wrap to 0", count, 0);
        check("R6 carry returns high", carry_n, 1);
    endtask

    task automatic t_down_wrap();
        dn = 1'b0; tick(4);
        check("R7 borrow low at 0", borrow_n, 0);
        dn = 1'b1; tick(4);
        check("R2 wrap to 15", count, 15);
        check("R7 borrow returns high", borrow_n, 1);
        pulse_dn();
        check("R2 count down", count, 14);
    endtask

    task automatic t_load();
        up = 1'b0;
        din = 4'd5; load_n = 1'b0; tick(3);
        load_n = 1'b1; din = 4'd0; tick(2);
        check("R4 load value", count, 5);
        up = 1'b1; tick(4);
        check("R8 edge after load counted", count, 6);
        // load overrides a rising strobe
        up = 1'b0; tick(4);
        din = 4'd9; load_n = 1'b0; up = 1'b1; tick(5);
        load_n = 1'b1; tick(2);
        check("R4 load beats strobe", count, 9);
    endtask

    task automatic t_clear();
        dn = 1'b0; tick(3);
        clr = 1'b1; load_n = 1'b0; din = 4'd12; tick(2);
        check("R3 clear beats load", count, 0);
        clr = 1'b0; load_n = 1'b1; tick(2);
        check("R3 count held at 0", count, 0);
        dn = 1'b1; tick(4);
        check("R8 edge after clear counted", count, 15);
    endtask

    task automatic t_both();
        up = 1'b0; dn = 1'b0; tick(4);
        up = 1'b1; dn = 1'b1; tick(5);
        check("R9 both edges hold", count, 15);
    endtask

    task automatic t_ignore();
        dn = 1'b0; tick(4);
        pulse_up();
        check("R10 up ignored while down low", count, 15);
        dn = 1'b1; tick(4);
        check("R2 down edge with up high", count, 14);
    endtask

    task automatic t_cascade();
        for (int i = 0; i < 16; i++) begin
            c_up = 1'b0; tick(4);
            c_up = 1'b1; tick(4);
        end
        tick(4);
        check("R12 low stage wrapped", lo_cnt, 0);
        check("R12 high stage carried", hi_cnt, 1);
        c_dn = 1'b0; tick(4);
        c_dn = 1'b1; tick(8);
        check("R12 low stage borrowed", lo_cnt, 15);
        check("R12 high stage decremented", hi_cnt, 0);
    endtask

    initial begin
        tick(1);
        t_reset();
        t_latency();
        t_up_wrap();
        t_down_wrap();
        t_load();
        t_clear();
        t_both();
        t_ignore();
        t_cascade();
        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        #(8 * 20000);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

endmodule